// File: doc/BRIEF.md
# SDRAM Command Sequence Checker

This block watches the command pins between a memory controller and a four-bank single-data-rate SDRAM, and it reports the first command that breaks the sequencing rules. On every clock it decodes chip-select, row strobe, column strobe, write enable and clock enable into one command. It keeps a state per bank (idle, open, or in an auto-precharge burst) with a down-counter for that bank. It also keeps a two-cycle guard after a mode-register load and a flag for self refresh.

The checker only observes the bus and never drives it. When a rule is broken it raises a sticky flag with a 3-bit code naming the rule. The flag stays until a synchronous clear. A command found illegal is not applied to the bank model, so the model keeps following what the controller should have done. The burst length, the precharge time (tRP) and the activate-to-column time (tRCD) are parameters. Their defaults are 4, 3 and 3 clocks.

Top module: `sdram_cmd_checker`

## Requirements
- R1: After reset, and after any later reset, `viol_o` is 0 and `err_code_o` is 0.
- R2: A command is sampled only when clock enable was high in the previous cycle and `cs_n_i` is low. The {ras_n,cas_n,we_n} encodings are: 000 mode load, 001 refresh, 011 activate, 101 read, 100 write, 110 burst stop, 010 precharge, 111 no-op. A high `cs_n_i` acts as a no-op. `ba_i` value n (00,01,10,11) selects bank n.
- R3: A mode load, an auto refresh or a self-refresh entry is legal only when every bank is idle and its tRP has elapsed. Otherwise the code is 1.
- R4: Any command other than a no-op in the cycle right after a legal mode load gives code 6.
- R5: An activate to a bank that is not idle gives code 3. An activate to an idle bank before tRP has elapsed since its precharge gives code 4. An activate is legal at the precharge cycle plus T_RP.
- R6: A read or write to a bank that is not open gives code 2. A read or write before tRCD has elapsed since the activate gives code 4. A read or write is legal at the activate cycle plus T_RCD.
- R7: A read or write with `a10_i` high starts an auto-precharge burst of BURST_LEN cycles. While it runs, any read or write to any bank, and any precharge that covers the bursting bank, gives code 5. The bank then closes itself, and an activate to it is legal at the command cycle plus BURST_LEN plus T_RP.
- R8: A precharge with `a10_i` high closes every open bank and ignores `ba_i`. With `a10_i` low it closes only the selected bank.
- R9: A burst stop is always legal. It ends a running auto-precharge burst, so the bank closes on the next cycle and its tRP starts then.
- R10: A refresh with clock enable going from high to low enters self refresh. Commands are ignored while the previous-cycle clock enable is low. In the first sampled cycle after clock enable returns high, any command other than a no-op gives code 7.
- R11: The first violation's code is latched with `viol_o` high and held, whatever follows, until `clr_i`. A violation in the same cycle as `clr_i` is dropped. A command found illegal does not change any bank state.
- R12: When several rules fail at once, code 6 wins over code 7, and code 7 wins over any per-command rule. For reads and writes, code 5 wins over codes 2 and 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Synchronous clear of the violation flag and code |
| cke_i | input | 1 | Clock enable line |
| cs_n_i | input | 1 | Chip select, active low |
| ras_n_i | input | 1 | Row strobe, active low |
| cas_n_i | input | 1 | Column strobe, active low |
| we_n_i | input | 1 | Write enable, active low |
| ba_i | input | 2 | Bank address |
| a10_i | input | 1 | Auto-precharge / all-bank select line |
| viol_o | output | 1 | Sticky violation flag |
| err_code_o | output | 3 | Code of the first violation, 0 when none |

## Verification
The hardest case to reach is the cycle right after self-refresh exit. It needs a clean entry, several clock-enable-low cycles carrying commands that must be ignored, and then a rising clock enable. The bench builds this with directed steps after the table pass. It then proves that the activates sent during self refresh were dropped: a later activate to the same bank must be accepted. A second hard case is the closing of an auto-precharge burst. Here the bench probes the exact cycles where the burst ends and where tRP ends, including an early end through burst stop.

// File: rtl/sdram_chk_pkg.sv
package sdram_chk_pkg;

  typedef enum logic [3:0] {
    CMD_NOP, CMD_ACT, CMD_RD, CMD_WR, CMD_PRE,
    CMD_REF, CMD_SREF, CMD_MRS, CMD_BST
  } cmd_e;

  typedef enum logic [1:0] {
    BK_IDLE, BK_OPEN, BK_AP_BURST
  } bank_st_e;

  typedef enum logic [2:0] {
    ERR_NONE         = 3'd0,
    ERR_NOT_IDLE     = 3'd1,
    ERR_NOT_OPEN     = 3'd2,
    ERR_ALREADY_OPEN = 3'd3,
    ERR_TIMING       = 3'd4,
    ERR_AP_LOCK      = 3'd5,
    ERR_MRS_GAP      = 3'd6,
    ERR_SREF_EXIT    = 3'd7
  } err_e;

endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
  import sdram_chk_pkg::*;
(
  input  logic cke_q_i,
  input  logic cke_i,
  input  logic cs_n_i,
  input  logic ras_n_i,
  input  logic cas_n_i,
  input  logic we_n_i,
  output cmd_e cmd_o
);
  always_comb begin
    cmd_o = CMD_NOP;
    if (cke_q_i && !cs_n_i) begin
      unique case ({ras_n_i, cas_n_i, we_n_i})
        3'b000: cmd_o = CMD_MRS;
        3'b001: cmd_o = cke_i ? CMD_REF : CMD_SREF;
        3'b011: cmd_o = CMD_ACT;
        3'b101: cmd_o = CMD_RD;
        3'b100: cmd_o = CMD_WR;
        3'b110: cmd_o = CMD_BST;
        3'b010: cmd_o = CMD_PRE;
        default: cmd_o = CMD_NOP;
      endcase
    end
  end
endmodule

// File: rtl/sdram_bank_fsm.sv
module sdram_bank_fsm
  import sdram_chk_pkg::*;
#(
  parameter int unsigned CNT_W     = 3,
  parameter int unsigned BURST_LEN = 4,
  parameter int unsigned T_RP      = 3,
  parameter int unsigned T_RCD     = 3
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     act_i,
  input  logic     rdwr_i,
  input  logic     ap_i,
  input  logic     pre_i,
  input  logic     bst_i,
  output bank_st_e st_o,
  output logic     tdone_o
);
  localparam logic [CNT_W-1:0] RCD_LD = CNT_W'(T_RCD - 1);
  localparam logic [CNT_W-1:0] RP_LD  = CNT_W'(T_RP - 1);
  localparam logic [CNT_W-1:0] BL_LD  = CNT_W'(BURST_LEN - 1);

  bank_st_e         st_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= BK_IDLE;
      cnt_q <= '0;
    end else begin
      unique case (st_q)
        BK_IDLE: begin
          if (act_i) begin
            st_q  <= BK_OPEN;
            cnt_q <= RCD_LD;
          end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        BK_OPEN: begin
          if (pre_i) begin
            st_q  <= BK_IDLE;
            cnt_q <= RP_LD;
          end else if (rdwr_i && ap_i) begin
            st_q  <= BK_AP_BURST;
            cnt_q <= BL_LD;
          end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        BK_AP_BURST: begin
          if (cnt_q == '0) begin
            st_q  <= BK_IDLE;
            cnt_q <= RP_LD;
          end else if (bst_i) begin
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        default: begin
          st_q  <= BK_IDLE;
          cnt_q <= '0;
        end
      endcase
    end
  end

  assign st_o    = st_q;
  assign tdone_o = (cnt_q == '0);
endmodule

// File: rtl/sdram_rule_check.sv
module sdram_rule_check
  import sdram_chk_pkg::*;
#(
  parameter int unsigned NB   = 4,
  parameter int unsigned BA_W = 2
) (
  input  cmd_e            cmd_i,
  input  logic [BA_W-1:0] ba_i,
  input  logic            a10_i,
  input  bank_st_e        st_i    [NB],
  input  logic [NB-1:0]   tdone_i,
  input  logic            mrs_busy_i,
  input  logic            sref_pend_i,
  output err_e            err_o,
  output logic [NB-1:0]   ap_busy_o
);
  logic all_idle;
  logic any_ap;
  bank_st_e sel_st;
  logic     sel_done;

  always_comb begin
    all_idle = 1'b1;
    for (int i = 0; i < NB; i++) begin
      ap_busy_o[i] = (st_i[i] == BK_AP_BURST) && !tdone_i[i];
      if (st_i[i] != BK_IDLE || !tdone_i[i]) all_idle = 1'b0;
    end
    any_ap   = |ap_busy_o;
    sel_st   = st_i[ba_i];
    sel_done = tdone_i[ba_i];
  end

  always_comb begin
    err_o = ERR_NONE;
    if (cmd_i != CMD_NOP) begin
      if (mrs_busy_i) begin
        err_o = ERR_MRS_GAP;
      end else if (sref_pend_i) begin
        err_o = ERR_SREF_EXIT;
      end else begin
        unique case (cmd_i)
          CMD_MRS, CMD_REF, CMD_SREF:
            if (!all_idle) err_o = ERR_NOT_IDLE;
          CMD_ACT:
            if (sel_st != BK_IDLE) err_o = ERR_ALREADY_OPEN;
            else if (!sel_done)    err_o = ERR_TIMING;
          CMD_RD, CMD_WR:
            if (any_ap)                 err_o = ERR_AP_LOCK;
            else if (sel_st != BK_OPEN) err_o = ERR_NOT_OPEN;
            else if (!sel_done)         err_o = ERR_TIMING;
          CMD_PRE:
            if (a10_i ? any_ap : ap_busy_o[ba_i]) err_o = ERR_AP_LOCK;
          default: err_o = ERR_NONE;
        endcase
      end
    end
  end
endmodule

// File: rtl/sdram_cmd_checker.sv
module sdram_cmd_checker
  import sdram_chk_pkg::*;
#(
  parameter int unsigned BA_W      = 2,
  parameter int unsigned BURST_LEN = 4,
  parameter int unsigned T_RP      = 3,
  parameter int unsigned T_RCD     = 3,
  parameter int unsigned MRS_GAP   = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic            cke_i,
  input  logic            cs_n_i,
  input  logic            ras_n_i,
  input  logic            cas_n_i,
  input  logic            we_n_i,
  input  logic [BA_W-1:0] ba_i,
  input  logic            a10_i,
  output logic            viol_o,
  output logic [2:0]      err_code_o
);
  localparam int unsigned NB      = 1 << BA_W;
  localparam int unsigned CNT_MAX = (T_RP > T_RCD ? (T_RP > BURST_LEN ? T_RP : BURST_LEN)
                                                  : (T_RCD > BURST_LEN ? T_RCD : BURST_LEN));
  localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);
  localparam int unsigned MRS_W   = $clog2(MRS_GAP + 1);
  localparam logic [MRS_W-1:0] MRS_LD = MRS_W'(MRS_GAP - 1);

  logic             cke_q;
  cmd_e             cmd;
  err_e             err;
  logic             legal;
  bank_st_e         bank_st [NB];
  logic [NB-1:0]    bank_tdone;
  logic [NB-1:0]    ap_busy;
  logic [MRS_W-1:0] mrs_cnt_q;
  logic             mrs_busy;
  logic             sref_q;
  logic             sref_pend;
  logic             viol_q;
  err_e             code_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cke_q <= 1'b0;
    else         cke_q <= cke_i;
  end

  sdram_cmd_decode u_decode (
    .cke_q_i (cke_q),
    .cke_i   (cke_i),
    .cs_n_i  (cs_n_i),
    .ras_n_i (ras_n_i),
    .cas_n_i (cas_n_i),
    .we_n_i  (we_n_i),
    .cmd_o   (cmd)
  );

  assign mrs_busy  = (mrs_cnt_q != '0);
  assign sref_pend = sref_q && cke_q;

  sdram_rule_check #(.NB(NB), .BA_W(BA_W)) u_rules (
    .cmd_i       (cmd),
    .ba_i        (ba_i),
    .a10_i       (a10_i),
    .st_i        (bank_st),
    .tdone_i     (bank_tdone),
    .mrs_busy_i  (mrs_busy),
    .sref_pend_i (sref_pend),
    .err_o       (err),
    .ap_busy_o   (ap_busy)
  );

  assign legal = (err == ERR_NONE);

  for (genvar g = 0; g < NB; g++) begin : g_bank
    logic hit;
    assign hit = (ba_i == BA_W'(g));
    sdram_bank_fsm #(
      .CNT_W(CNT_W), .BURST_LEN(BURST_LEN), .T_RP(T_RP), .T_RCD(T_RCD)
    ) u_bank (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .act_i   (legal && cmd == CMD_ACT && hit),
      .rdwr_i  (legal && (cmd == CMD_RD || cmd == CMD_WR) && hit),
      .ap_i    (a10_i),
      .pre_i   (legal && cmd == CMD_PRE && (a10_i || hit)),
      .bst_i   (legal && cmd == CMD_BST),
      .st_o    (bank_st[g]),
      .tdone_o (bank_tdone[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mrs_cnt_q <= '0;
      sref_q    <= 1'b0;
    end else begin
      if (legal && cmd == CMD_MRS) mrs_cnt_q <= MRS_LD;
      else if (mrs_busy)           mrs_cnt_q <= mrs_cnt_q - 1'b1;
      if (legal && cmd == CMD_SREF) sref_q <= 1'b1;
      else if (sref_pend)           sref_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      viol_q <= 1'b0;
      code_q <= ERR_NONE;
    end else if (clr_i) begin
      viol_q <= 1'b0;
      code_q <= ERR_NONE;
    end else if (!viol_q && !legal) begin
      viol_q <= 1'b1;
      code_q <= err;
    end
  end

  assign viol_o     = viol_q;
  assign err_code_o = code_q;
endmodule

// File: rtl/sdram_cmd_checker_sva.sv
module sdram_cmd_checker_sva #(
  parameter int unsigned NB = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          clr_i,
  input logic          cke_i,
  input logic          cs_n_i,
  input logic          ras_n_i,
  input logic          cas_n_i,
  input logic          we_n_i,
  input logic          viol_o,
  input logic [2:0]    err_code_o,
  input logic          mrs_busy,
  input logic [NB-1:0] ap_busy
);
  logic cke_seen_q;
  logic live_cmd;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cke_seen_q <= 1'b0;
    else         cke_seen_q <= cke_i;
  end

  assign live_cmd = cke_seen_q && !cs_n_i && !(ras_n_i && cas_n_i && we_n_i);

  assert_code_matches_flag_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    viol_o == (err_code_o != 3'd0));

  assert_sticky_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (viol_o && !clr_i) |=> (viol_o && $stable(err_code_o)));

  assert_clear_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !viol_o);

  assert_single_ap_burst_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ap_busy));

  assert_mrs_gap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mrs_busy && live_cmd && !viol_o && !clr_i) |=> (viol_o && err_code_o == 3'd6));
endmodule

bind sdram_cmd_checker sdram_cmd_checker_sva #(.NB(NB)) u_sva (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .clr_i      (clr_i),
  .cke_i      (cke_i),
  .cs_n_i     (cs_n_i),
  .ras_n_i    (ras_n_i),
  .cas_n_i    (cas_n_i),
  .we_n_i     (we_n_i),
  .viol_o     (viol_o),
  .err_code_o (err_code_o),
  .mrs_busy   (mrs_busy),
  .ap_busy    (ap_busy)
);

// File: tb/sdram_cmd_checker_bench.sv
module sdram_cmd_checker_bench;
  // {cs_n,ras_n,cas_n,we_n}
  localparam logic [3:0] C_NOP = 4'b0111, C_DES = 4'b1111, C_MRS = 4'b0000,
                         C_REF = 4'b0001, C_ACT = 4'b0011, C_RD  = 4'b0101,
                         C_WR  = 4'b0100, C_BST = 4'b0110, C_PRE = 4'b0010;
  localparam int NV = 51;
  // {cmd[11:8], ba[7:6], a10[5], clr[4], exp_viol[3], exp_code[2:0]}
  localparam logic [11:0] VEC [NV] = '{
    {C_NOP, 2'd0, 1'b0, 1'b0, 1'b0, 3'd0}, // 0  R2
    {C_MRS, 2'd0, 1'b0, 1'b0, 1'b0, 3'd0}, // 1  R3 legal mode load
    {C_NOP, 2'd0, 1'b0, 1'b0, 1'b0, 3'd0}, // 2  R4 gap no-op
    {C_ACT, 2'd0, 1'b0, 1'b0, 1'b0, 3'd0}, // 3  R4 first legal slot
    {C_DES, 2'd3, 1'b1, 1'b0, 1'b0, 3'd0}, // 4  R2 deselect
    {C_NOP, 2'd0, 1'b0, 1'b0, 1'b0, 3'd0}, // 5
    {C_RD,  2'd0, 1'b0, 1'b0, 1'b0, 3'd0}, // 6  R6 at tRCD
    {C_WR,  2'd0, 1'b0, 1'b0, 1'b0, 3'd0}, // 7  R6
    {C_ACT, 2'd1, 1'b0, 1'b0, 1'b0, 3'd0}, // 8  R2 bank 1
    {C_RD,  2'd1, 1'b0, 1'b0, 1'b1, 3'd4}, // 9  R6 early
    {C_NOP, 2'd0, 1'b0, 1'b1, 1'b0, 3'd0}, // 10 R11 clear
    {C_RD,  2'd1, 1'b1, 1'b0, 1'b0, 3'd0}, // 11 R7 start AP burst
    {C_RD,  2'd0, 1'b0, 1'b0, 1'b1, 3'd5}, // 12 R7 lockout
    {C_NOP, 2'd0, 1'b0, 1'b1, 1'b0, 3'd0}, // 13
    {C_NOP, 2'd0, 1'b0, 1'b0, 1'b0, 3'd0}, // 14
    {C_RD,  2'd0, 1'b0, 1'b0, 1'b0, 3'd0}, // 15 R7 burst over
    {C_ACT, 2'd1, 1'b0, 1'b0, 1'b1, 3'd4}, // 16 R7 tRP not met
    {C_NOP, 2'd0, 1'b0, 1'b1, 1'b0, 3'd0}, // 17
    {C_ACT, 2'd1, 1'b0, 1'b0, 1'b0, 3'd0}, // 18 R7 R5 cmd+BL+tRP
    {C_PRE, 2'd3, 1'b1, 1'b0, 1'b0, 3'd0}, // 19 R8 all, ba ignored
    {C_REF, 2'd0, 1'b0, 1'b0, 1'b1, 3'd1}, // 20 R3 tRP pending
    {C_NOP, 2'd0, 1'b0, 1'b1, 1'b0, 3'd0}, // 21
    {C_REF, 2'd0, 1'b0, 1'b0, 1'b0, 3'd0}, // 22 R3 auto refresh ok
    {C_ACT, 2'd2, 1'b0, 1'b0, 1'b0, 3'd0}, // 23
    {C_MRS, 2'd0, 1'b0, 1'b0, 1'b1, 3'd1}, // 24 R3 bank open
    {C_NOP, 2'd0, 1'b0, 1'b1, 1'b0, 3'd0}, // 25
    {C_PRE, 2'd2, 1'b0, 1'b0, 1'b0, 3'd0}, // 26 R8 single
    {C_MRS, 2'd0, 1'b0, 1'b0, 1'b1, 3'd1}, // 27 R3 tRP pending
    {C_NOP, 2'd0, 1'b0, 1'b1, 1'b0, 3'd0}, // 28
    {C_MRS, 2'd0, 1'b0, 1'b0, 1'b0, 3'd0}, // 29 R3
    {C_ACT, 2'd3, 1'b0, 1'b0, 1'b1, 3'd6}, // 30 R4
    {C_NOP, 2'd0, 1'b0, 1'b1, 1'b0, 3'd0}, // 31
    {C_WR,  2'd3, 1'b0, 1'b0, 1'b1, 3'd2}, // 32 R6 R11 act dropped
    {C_NOP, 2'd0, 1'b0, 1'b1, 1'b0, 3'd0}, // 33
    {C_ACT, 2'd3, 1'b0, 1'b0, 1'b0, 3'd0}, // 34
    {C_ACT, 2'd3, 1'b0, 1'b0, 1'b1, 3'd3}, // 35 R5 already open
    {C_NOP, 2'd0, 1'b0, 1'b1, 1'b0, 3'd0}, // 36
    {C_WR,  2'd3, 1'b1, 1'b0, 1'b0, 3'd0}, // 37 R7 write AP
    {C_BST, 2'd0, 1'b0, 1'b0, 1'b0, 3'd0}, // 38 R9
    {C_RD,  2'd3, 1'b0, 1'b0, 1'b1, 3'd2}, // 39 R9 lock gone, bank closing
    {C_NOP, 2'd0, 1'b0, 1'b1, 1'b0, 3'd0}, // 40
    {C_ACT, 2'd3, 1'b0, 1'b0, 1'b1, 3'd4}, // 41 R9 tRP from stop
    {C_NOP, 2'd0, 1'b0, 1'b1, 1'b0, 3'd0}, // 42
    {C_ACT, 2'd3, 1'b0, 1'b0, 1'b0, 3'd0}, // 43 R9 R5
    {C_RD,  2'd0, 1'b0, 1'b0, 1'b1, 3'd2}, // 44 R11 first
    {C_ACT, 2'd3, 1'b0, 1'b0, 1'b1, 3'd2}, // 45 R11 held
    {C_NOP, 2'd0, 1'b0, 1'b1, 1'b0, 3'd0}, // 46
    {C_RD,  2'd0, 1'b0, 1'b1, 1'b0, 3'd0}, // 47 R11 dropped with clear
    {C_RD,  2'd3, 1'b1, 1'b0, 1'b0, 3'd0}, // 48 R7
    {C_PRE, 2'd0, 1'b1, 1'b0, 1'b1, 3'd5}, // 49 R7 R8 precharge-all blocked
    {C_NOP, 2'd0, 1'b0, 1'b1, 1'b0, 3'd0}  // 50
  };

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       clr_i = 1'b0;
  logic       cke_i = 1'b1;
  logic       cs_n_i = 1'b1, ras_n_i = 1'b1, cas_n_i = 1'b1, we_n_i = 1'b1;
  logic [1:0] ba_i = 2'd0;
  logic       a10_i = 1'b0;
  logic       viol_o;
  logic [2:0] err_code_o;
  int         checks = 0;
  int         errors = 0;
  bit         done = 1'b0;

  always #4 clk_i = ~clk_i;

  sdram_cmd_checker u_sdram_cmd_checker (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr_i), .cke_i(cke_i),
    .cs_n_i(cs_n_i), .ras_n_i(ras_n_i), .cas_n_i(cas_n_i), .we_n_i(we_n_i),
    .ba_i(ba_i), .a10_i(a10_i), .viol_o(viol_o), .err_code_o(err_code_o)
  );

  task automatic drive(input logic [3:0] c, input logic [1:0] b, input logic a,
                       input logic k, input logic cl);
    {cs_n_i, ras_n_i, cas_n_i, we_n_i} = c;
    ba_i = b; a10_i = a; cke_i = k; clr_i = cl;
  endtask

  task automatic check(input string req, input logic ev, input logic [2:0] ec);
    checks++;
    if (viol_o !== ev || err_code_o !== ec) begin
      errors++;
      $display("FAIL %s: viol=%0b code=%0d expected viol=%0b code=%0d",
               req, viol_o, err_code_o, ev, ec);
    end
  endtask

  task automatic step(input logic [3:0] c, input logic [1:0] b, input logic a,
                      input logic k, input logic cl, input string req,
                      input logic ev, input logic [2:0] ec);
    drive(c, b, a, k, cl);
    @(posedge clk_i);
    @(negedge clk_i);
    check(req, ev, ec);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    check("R1 reset", 1'b0, 3'd0);
    rst_ni = 1'b1;
    for (int i = 0; i < NV; i++) begin
      step(VEC[i][11:8], VEC[i][7:6], VEC[i][5], 1'b1, VEC[i][4],
           $sformatf("table row %0d", i), VEC[i][3], VEC[i][2:0]);
    end
    // self refresh, R10
    repeat (6) step(C_NOP, 2'd0, 1'b0, 1'b1, 1'b0, "R10 settle", 1'b0, 3'd0);
    step(C_REF, 2'd0, 1'b0, 1'b0, 1'b0, "R10 entry", 1'b0, 3'd0);
    step(C_ACT, 2'd0, 1'b0, 1'b0, 1'b0, "R10 ignored", 1'b0, 3'd0);
    step(C_ACT, 2'd0, 1'b0, 1'b0, 1'b0, "R10 ignored", 1'b0, 3'd0);
    step(C_NOP, 2'd0, 1'b0, 1'b1, 1'b0, "R10 exit", 1'b0, 3'd0);
    step(C_ACT, 2'd0, 1'b0, 1'b1, 1'b0, "R10 exit guard", 1'b1, 3'd7);
    step(C_NOP, 2'd0, 1'b0, 1'b1, 1'b1, "R11 clear", 1'b0, 3'd0);
    step(C_ACT, 2'd0, 1'b0, 1'b1, 1'b0, "R10 earlier act dropped", 1'b0, 3'd0);
    // R8 single-bank precharge leaves others open
    step(C_ACT, 2'd1, 1'b0, 1'b1, 1'b0, "R2 bank 1", 1'b0, 3'd0);
    step(C_PRE, 2'd1, 1'b0, 1'b1, 1'b0, "R8 single", 1'b0, 3'd0);
    step(C_NOP, 2'd0, 1'b0, 1'b1, 1'b0, "R8", 1'b0, 3'd0);
    step(C_RD,  2'd0, 1'b0, 1'b1, 1'b0, "R8 bank 0 still open", 1'b0, 3'd0);
    step(C_ACT, 2'd1, 1'b0, 1'b1, 1'b0, "R8 bank 1 closed", 1'b0, 3'd0);
    // R12: mode load gap wins over bank rule
    step(C_PRE, 2'd0, 1'b1, 1'b1, 1'b0, "R8", 1'b0, 3'd0);
    repeat (3) step(C_NOP, 2'd0, 1'b0, 1'b1, 1'b0, "R12 settle", 1'b0, 3'd0);
    step(C_MRS, 2'd0, 1'b0, 1'b1, 1'b0, "R3", 1'b0, 3'd0);
    step(C_RD,  2'd2, 1'b0, 1'b1, 1'b0, "R12 gap first", 1'b1, 3'd6);
    // R1 reset mid-run
    @(negedge clk_i);
    rst_ni = 1'b0;
    #2;
    check("R1 async reset", 1'b0, 3'd0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule